// File: doc/BRIEF.md
# H-Bridge Current Chopper Controller

This block produces the four switch commands for one H-bridge that feeds a single motor winding. Current is regulated by chopping at a constant frequency and varying the duty cycle. A chop tick from outside marks the start of each period, and the bridge is switched on at that point. For a fixed blanking window at the start of each on-time, the current-comparator input is ignored, so that switching transients cannot cut the pulse short. After the window, the first comparator trip switches the bridge off. The bridge then stays off until the next tick.

A direction bit chooses which diagonal pair of switches conducts. Each change of direction passes through a dead interval with every switch open. A new on-time then starts in the new direction, with the blanking window counted again from zero. A disable input opens every switch at once, in the same cycle.

A status output warns when the conduction time within one period goes above half the period. Chopping at duty cycles above about 50 % can become unstable, so this flag marks that region. All intervals are counted in system clock cycles. The default parameters match a chop rate near 23 kHz with a blanking window near 1 µs, at a 100 MHz system clock.

Top module: `hbridge_chopper`

## Requirements
- R1: During reset and after its release, gate_o is 0000 and duty_warn_o is 0 until the first chop tick. The first DEAD_CYC cycles after reset count as a dead interval.
- R2: The bits of gate_o are: bit0 = high switch of leg A, bit1 = low switch of leg A, bit2 = high switch of leg B, bit3 = low switch of leg B. While the bridge conducts with phase_i = 1, gate_o is 1001. With phase_i = 0, gate_o is 0110. Bits 0 and 1 are never both 1, and bits 2 and 3 are never both 1.
- R3: A chop tick sampled with no dead interval pending makes the bridge conduct from the next cycle.
- R4: During the first BLANK_CYC conducting cycles of a period, trip_i is ignored. With trip_i held high, the bridge conducts for exactly BLANK_CYC + 1 cycles.
- R5: A trip sampled after the blanking window turns gate_o to 0000 from the next cycle. The bridge stays off, whatever trip_i does, until the next chop tick or phase change.
- R6: A chop tick that arrives while the bridge conducts starts a new period. Blanking restarts from zero at that tick.
- R7: When phase_i changes, gate_o keeps its old value in the cycle in which the change is sampled. It is then 0000 for exactly DEAD_CYC cycles. After that, the bridge conducts in the new direction with fresh blanking.
- R8: While disable_i is 1, gate_o is 0000 in the same cycle. After disable_i returns to 0, the bridge stays off until the next chop tick.
- R9: A chop tick sampled during a dead interval does not shorten it. A phase change sampled while disable_i is 1 still starts a full dead interval.
- R10: duty_warn_o is 1 once the number of conducting cycles since the last period start exceeds PERIOD_CYC/2. It returns to 0 in the cycle after a chop tick, a phase change or disable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chop_tick_i | input | 1 | One-cycle pulse that marks the start of a chop period |
| trip_i | input | 1 | Current comparator: winding current has reached its limit |
| phase_i | input | 1 | Direction: 1 drives current from terminal A to terminal B |
| disable_i | input | 1 | Opens all four switches while high |
| gate_o | output | 4 | Switch commands, bit order as given in R2 |
| duty_warn_o | output | 1 | Conduction time in this period exceeds half the period |

## Verification
disable_i reaches gate_o in the same cycle. Every other input acts one cycle after the edge that samples it: ticks, trips and phase changes. A phase change gives DEAD_CYC open cycles. A tick with a comparator held high gives BLANK_CYC + 1 conducting cycles. The warning rises after PERIOD_CYC/2 + 1 conducting cycles. The bench applies inputs on the falling edge and samples the outputs 1 ns later, in the same cycle. It steps a reference model at that same point, so each expectation lines up with the cycle in which the design is due to respond. The directed checks count open and conducting cycles over whole windows, so an off-by-one in either interval shows up as a wrong count.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    CH_WAIT  = 2'd0,
    CH_BLANK = 2'd1,
    CH_ON    = 2'd2
  } chop_state_e;
endpackage

// File: rtl/chop_dir_guard.sv
// Tracks the applied direction and times the all-open interval after each flip.
module chop_dir_guard #(
  parameter int DEAD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_i,
  output logic dir_o,
  output logic flip_o,
  output logic dead_busy_o
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CYC);

  logic          dir_q;
  logic [DW-1:0] dead_q;

  assign flip_o      = (phase_i != dir_q);
  assign dir_o       = dir_q;
  assign dead_busy_o = (dead_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      dead_q <= DEAD_LOAD;   // R1: reset behaves as a dead interval
    end else if (flip_o) begin
      dir_q  <= phase_i;
      dead_q <= DEAD_LOAD;
    end else if (dead_q != '0) begin
      dead_q <= dead_q - 1'b1;
    end
  end
endmodule

// File: rtl/chop_period_fsm.sv
// Per-period sequencing: blanking window, on-time, latched-off remainder.
module chop_period_fsm
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dis_i,
  input  logic        tick_i,
  input  logic        flip_i,
  input  logic        trip_i,
  input  logic        dead_busy_i,
  output chop_state_e st_o,
  output logic        conduct_o
);
  localparam int BW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
  localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_CYC - 1);

  chop_state_e   st_q;
  logic [BW-1:0] blank_q;

  assign st_o      = st_q;
  assign conduct_o = !dead_busy_i && (st_q != CH_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= CH_WAIT;
      blank_q <= '0;
    end else if (dis_i) begin
      st_q    <= CH_WAIT;
      blank_q <= '0;
    end else if (flip_i || tick_i) begin
      st_q    <= CH_BLANK;
      blank_q <= '0;
    end else begin
      unique case (st_q)
        CH_BLANK: begin
          if (!dead_busy_i) begin
            if (blank_q == BLANK_LAST) st_q <= CH_ON;
            else                       blank_q <= blank_q + 1'b1;
          end
        end
        CH_ON: begin
          if (trip_i) st_q <= CH_WAIT;
        end
        default: st_q <= st_q;
      endcase
    end
  end
endmodule

// File: rtl/chop_duty_mon.sv
// Counts conducting cycles since the last period start; flags beyond half.
module chop_duty_mon #(
  parameter int PERIOD_CYC = 4348
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic active_i,
  output logic warn_o
);
  localparam int HALF_CYC = PERIOD_CYC / 2;
  localparam int OW = $clog2(HALF_CYC + 2);
  localparam logic [OW-1:0] HALF_V = OW'(HALF_CYC);

  logic [OW-1:0] on_q;

  assign warn_o = (on_q > HALF_V);

  always_ff @(posedge clk) begin
    if (!rst_n)                         on_q <= '0;
    else if (restart_i)                 on_q <= '0;
    else if (active_i && on_q <= HALF_V) on_q <= on_q + 1'b1;
  end
endmodule

// File: rtl/chop_gate_map.sv
// Maps direction and conduction onto the two legs' high/low switches.
module chop_gate_map #(
  parameter int LEGS = 2
) (
  input  logic            active_i,
  input  logic            dir_i,
  output logic [2*LEGS-1:0] gate_o
);
  for (genvar k = 0; k < LEGS; k++) begin : g_leg
    // leg A (k=0) sources current when dir=1, leg B (k=1) when dir=0
    localparam logic SRC_DIR = (k == 0) ? 1'b1 : 1'b0;
    assign gate_o[2*k]   = active_i && (dir_i == SRC_DIR);
    assign gate_o[2*k+1] = active_i && (dir_i != SRC_DIR);
  end
endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 4348,
  parameter int BLANK_CYC  = 100,
  parameter int DEAD_CYC   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chop_tick_i,
  input  logic       trip_i,
  input  logic       phase_i,
  input  logic       disable_i,
  output logic [3:0] gate_o,
  output logic       duty_warn_o
);
  logic        dir_w;
  logic        flip_w;
  logic        dead_busy_w;
  logic        conduct_w;
  logic        active_w;
  chop_state_e st_w;

  chop_dir_guard #(.DEAD_CYC(DEAD_CYC)) u_dir (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i),
    .dir_o(dir_w), .flip_o(flip_w), .dead_busy_o(dead_busy_w)
  );

  chop_period_fsm #(.BLANK_CYC(BLANK_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dis_i(disable_i), .tick_i(chop_tick_i),
    .flip_i(flip_w), .trip_i(trip_i), .dead_busy_i(dead_busy_w),
    .st_o(st_w), .conduct_o(conduct_w)
  );

  assign active_w = conduct_w && !disable_i;

  chop_duty_mon #(.PERIOD_CYC(PERIOD_CYC)) u_mon (
    .clk(clk), .rst_n(rst_n),
    .restart_i(disable_i || chop_tick_i || flip_w),
    .active_i(active_w), .warn_o(duty_warn_o)
  );

  chop_gate_map #(.LEGS(2)) u_map (
    .active_i(active_w), .dir_i(dir_w), .gate_o(gate_o)
  );
endmodule

// File: rtl/hbridge_chopper_chk.sv
module hbridge_chopper_chk
  import chop_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        chop_tick_i,
  input logic        trip_i,
  input logic        phase_i,
  input logic        disable_i,
  input logic [3:0]  gate_o,
  input logic        duty_warn_o,
  input logic        dir_i,
  input logic        dead_busy_i,
  input chop_state_e st_i
);
  p_leg_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]));

  p_disable_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |-> (gate_o == 4'b0000));

  p_dead_after_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != $past(phase_i)) |=> (gate_o == 4'b0000));

  p_tick_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_tick_i && !disable_i && phase_i == dir_i && !dead_busy_i) |=>
      (disable_i || gate_o != 4'b0000));

  p_blank_ignores_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == CH_BLANK && !dead_busy_i && !disable_i && !chop_tick_i &&
     phase_i == dir_i && trip_i) |=> (st_i != CH_WAIT));

  p_off_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == CH_WAIT && !chop_tick_i && phase_i == dir_i) |=> (gate_o == 4'b0000));

  p_warn_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chop_tick_i |=> !duty_warn_o);
endmodule

bind hbridge_chopper hbridge_chopper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chop_tick_i(chop_tick_i), .trip_i(trip_i),
  .phase_i(phase_i), .disable_i(disable_i), .gate_o(gate_o),
  .duty_warn_o(duty_warn_o), .dir_i(dir_w), .dead_busy_i(dead_busy_w),
  .st_i(st_w)
);

// File: tb/hbridge_chopper_tb_top.sv
`timescale 1ns/1ps
module hbridge_chopper_tb_top;
  localparam int P = 40;
  localparam int B = 5;
  localparam int D = 3;
  localparam int HALF = P / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chop_tick_i = 1'b0, trip_i = 1'b0, phase_i = 1'b0, disable_i = 1'b0;
  logic [3:0] gate_o;
  logic duty_warn_o;

  always #4 clk = ~clk;

  hbridge_chopper #(.PERIOD_CYC(P), .BLANK_CYC(B), .DEAD_CYC(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .chop_tick_i(chop_tick_i), .trip_i(trip_i),
    .phase_i(phase_i), .disable_i(disable_i), .gate_o(gate_o),
    .duty_warn_o(duty_warn_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_dir, m_dead, m_st, m_b, m_on;
  logic [3:0] last_g;

  function automatic logic [3:0] exp_gate(input int dir, dead, st, input logic dis);
    if (dis || dead != 0 || st == 0) return 4'b0000;
    return (dir != 0) ? 4'b1001 : 4'b0110;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dir = 0; m_dead = D; m_st = 0; m_b = 0; m_on = 0;
  endtask

  task automatic cyc(input logic t, tr, ph, ds, input string tag);
    logic [3:0] eg;
    int chg, cond;
    @(negedge clk);
    chop_tick_i = t; trip_i = tr; phase_i = ph; disable_i = ds;
    #1;
    last_g = gate_o;
    if (!rst_n) begin
      check(gate_o == 4'b0000, "R1 reset gates", gate_o, 0);
      check(duty_warn_o == 1'b0, "R1 reset warn", duty_warn_o, 0);
      model_reset();
      return;
    end
    eg = exp_gate(m_dir, m_dead, m_st, ds);
    check(gate_o == eg, tag, gate_o, eg);
    check(duty_warn_o == (m_on > HALF), {tag, " R10 warn"}, duty_warn_o, m_on > HALF);
    chg  = (int'(ph) != m_dir);
    cond = (eg != 4'b0000);
    if (ds || chg != 0 || t) m_on = 0;
    else if (cond != 0 && m_on <= HALF) m_on++;
    if (ds) begin m_st = 0; m_b = 0; end
    else if (chg != 0 || t) begin m_st = 1; m_b = 0; end
    else if (m_st == 1 && m_dead == 0) begin
      if (m_b == B - 1) m_st = 2; else m_b++;
    end else if (m_st == 2 && tr) m_st = 0;
    if (chg != 0) begin m_dir = int'(ph); m_dead = D; end
    else if (m_dead > 0) m_dead--;
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int cnt;
    int tcnt;
    logic ph;
    logic ds;
    int seed;
    seed = $urandom(32'd4711);
    model_reset();
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, "R1 idle until tick");

    // R3 R4 R5: tick with trip held high -> B+1 conducting cycles
    cyc(1, 1, 0, 0, "R3");
    cnt = 0;
    for (int i = 0; i < 15; i++) begin
      cyc(0, 1, 0, 0, "R4 blank");
      if (last_g != 0) cnt++;
    end
    check(cnt == B + 1, "R4 on-time with trip held", cnt, B + 1);
    check(last_g == 4'b0000, "R5 latched off", last_g, 0);

    // R6: tick during on-time restarts blanking
    cyc(1, 0, 0, 0, "R3");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, "R2 conduct dir0");
    check(last_g == 4'b0110, "R2 dir0 pattern", last_g, 4'b0110);
    cyc(1, 1, 0, 0, "R6 tick while on");
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      cyc(0, 1, 0, 0, "R6");
      if (last_g != 0) cnt++;
    end
    check(cnt == B + 1, "R6 blanking restarted", cnt, B + 1);

    // R10: warn threshold
    cyc(1, 0, 0, 0, "R10");
    for (int n = 1; n <= 25; n++) begin
      cyc(0, 0, 0, 0, "R10");
      if (n == HALF + 1) check(duty_warn_o == 1'b0, "R10 at half", duty_warn_o, 0);
      if (n == HALF + 2) check(duty_warn_o == 1'b1, "R10 beyond half", duty_warn_o, 1);
    end
    cyc(1, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, "R10");
    check(duty_warn_o == 1'b0, "R10 cleared by tick", duty_warn_o, 0);

    // R7: phase flip while conducting
    cyc(0, 0, 1, 0, "R7 flip cycle");
    check(last_g == 4'b0110, "R7 old value in flip cycle", last_g, 4'b0110);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 1, 0, "R7");
      if (last_g == 0) cnt++;
      else break;
    end
    check(cnt == D, "R7 dead cycles", cnt, D);
    check(last_g == 4'b1001, "R2 dir1 pattern", last_g, 4'b1001);

    // R9: tick during dead does not shorten it
    cyc(0, 0, 0, 0, "R9 flip");
    cyc(1, 0, 0, 0, "R9 tick in dead");
    cnt = 1;
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, 0, "R9");
      if (last_g == 0) cnt++;
      else break;
    end
    check(cnt == D, "R9 dead kept", cnt, D);

    // R8: disable
    cyc(0, 0, 0, 1, "R8");
    check(last_g == 4'b0000, "R8 same-cycle off", last_g, 0);
    cyc(0, 0, 1, 1, "R9 flip while disabled");
    cyc(0, 0, 1, 1, "R8");
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 1, 0, "R8 stays off");
      if (last_g != 0) cnt++;
    end
    check(cnt == 0, "R8 off until tick", cnt, 0);
    cyc(1, 0, 1, 0, "R3");
    cyc(0, 0, 1, 0, "R3");
    check(last_g == 4'b1001, "R3 on after tick", last_g, 4'b1001);

    // random phase
    ph = 1'b1; ds = 1'b0; tcnt = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 60 == 0) ph = ~ph;
      if (ds) ds = ($urandom % 4 != 0);
      else    ds = ($urandom % 80 == 0);
      cyc(tcnt == 0, ($urandom % 6 == 0), ph, ds, "R2 random");
      tcnt = (tcnt == P - 1) ? 0 : tcnt + 1;
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule